// File: doc/BRIEF.md
# Line-Buffered 2x4 Interpolating Upscaler

This block raises the sample density of an 8-bit pixel stream by two along a line and by four across lines. Each input pixel yields eight output samples. The samples serve as a finer grid for placing pixels after a coordinate rotation. The block keeps one earlier line in a single line buffer. When a new line streams in, each pixel is blended with the stored pixel of the same column to form four vertical phases. Each vertical phase is then averaged with its right-hand neighbour to form the half-pixel position. All arithmetic is linear with rounding, so the work keeps pace with the incoming video.

The input is a valid-qualified pixel stream. It carries a start-of-line flag and an end-of-line flag on the pixel beat, and a field-active level. The eight samples for a column come out on eight consecutive cycles. The samples for a column are emitted when the pixel to its right arrives. For the last pixel of a line they are emitted when that pixel arrives. The system clock must run at least eight times faster than the pixel rate.

Top module: `upscale_2x4`

## Requirements
- R1: After reset, out_valid stays low until a pixel that triggers a group has been accepted.
- R2: Every column produces exactly eight beats on consecutive cycles. The index {out_sub_line, out_sub_pix} counts 0 to 7 within a group, with sub-line in the upper two bits. Groups appear in column order.
- R3: A beat with out_sub_pix = 0 and sub-line j carries ((4-j)*P + j*C + 2) >> 2. Here C is the current-line pixel of that column and P is the stored previous-line pixel of the same column.
- R4: A beat with out_sub_pix = 1 carries (V0 + V1 + 1) >> 1. V0 is the R3 value of the column and V1 is the R3 value of the next column at the same sub-line.
- R5: For the last pixel of a line, including a one-pixel line, V1 is taken equal to V0, so both sub-pixel beats are equal.
- R6: In the first line of a field, P is taken equal to C, so all sub-lines of a column carry the same values.
- R7: The group for column k starts one cycle after the clock edge that accepts pixel k+1. The group for the last pixel starts one cycle after the edge that accepts that pixel. When both are due at the same edge, the last pixel's group follows the other group with no gap.
- R8: A rising edge of in_fv makes the next line a first line, whatever the line buffer holds. This also applies when the rising edge coincides with that line's first pixel.
- R9: Pixels may arrive as often as every 8 cycles, or every 16 cycles after an end-of-line pixel, with no lost or extra beats.
- R10: Lines of up to LINE_MAX = 768 pixels are supported, with every column using its own stored previous-line value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 8 | Input pixel value |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_eol | input | 1 | Marks the last pixel of a line |
| in_fv | input | 1 | Field active level; rising edge starts a field |
| out_valid | output | 1 | Output sample qualifier |
| out_pix | output | 8 | Interpolated sample |
| out_sub_line | output | 2 | Vertical phase 0..3 |
| out_sub_pix | output | 1 | Horizontal phase 0..1 |

## Verification
Two functions can fall in the same clock edge. First, at the minimum spacing of 8 cycles, a new pixel loads a fresh group on the same edge that registers the last beat of the previous group. Second, the field-active level can rise on the very cycle that carries the first pixel of a line. The bench drives lines at exactly that minimum spacing and raises the field level together with the first pixel. It then compares every beat's value, phase index and arrival cycle against a model built from the rounding formulas. A dropped beat, a doubled beat or a stale previous-line value therefore shows up as a mismatch.

// File: rtl/upscale_pkg.sv
package upscale_pkg;
    localparam int H_FACT    = 2;
    localparam int V_FACT    = 4;
    localparam int BEATS     = H_FACT * V_FACT;
    localparam int IDX_W     = $clog2(BEATS);
    localparam int SUBLINE_W = $clog2(V_FACT);
    typedef logic [IDX_W-1:0] beat_idx_t;
endpackage

// File: rtl/upscale_linebuf.sv
module upscale_linebuf #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 768,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIX_W-1:0]  wdata,
    output logic [PIX_W-1:0]  rdata
);
    logic [PIX_W-1:0] mem_q [DEPTH];

    // read returns the old contents; the write lands at the edge
    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    AST_LB_ADDR: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(addr) < DEPTH)); // R10
endmodule

// File: rtl/upscale_sample.sv
module upscale_sample
    import upscale_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]     cur_a,
    input  logic [PIX_W-1:0]     cur_b,
    input  logic [PIX_W-1:0]     prv_a,
    input  logic [PIX_W-1:0]     prv_b,
    input  logic [SUBLINE_W-1:0] sub_line,
    input  logic                 sub_pix,
    output logic [PIX_W-1:0]     samp
);
    localparam int ACC_W = PIX_W + 3;

    logic [PIX_W-1:0] cur  [H_FACT];
    logic [PIX_W-1:0] prv  [H_FACT];
    logic [PIX_W-1:0] vert [H_FACT];

    assign cur[0] = cur_a;
    assign cur[1] = cur_b;
    assign prv[0] = prv_a;
    assign prv[1] = prv_b;

    logic [2:0] w_cur;
    logic [2:0] w_prv;
    assign w_cur = {1'b0, sub_line};
    assign w_prv = 3'd4 - w_cur;

    // one vertical blender per horizontal neighbour
    for (genvar i = 0; i < H_FACT; i++) begin : g_vmix
        logic [ACC_W-1:0] acc;
        assign acc = ACC_W'(prv[i]) * ACC_W'(w_prv)
                   + ACC_W'(cur[i]) * ACC_W'(w_cur)
                   + ACC_W'(2);
        assign vert[i] = acc[PIX_W+1:2];
    end

    logic [PIX_W:0] msum;
    assign msum = {1'b0, vert[0]} + {1'b0, vert[1]} + {{PIX_W{1'b0}}, 1'b1};
    assign samp = sub_pix ? msum[PIX_W:1] : vert[0];
endmodule

// File: rtl/upscale_2x4.sv
module upscale_2x4
    import upscale_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int LINE_MAX = 768
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [PIX_W-1:0]     in_pix,
    input  logic                 in_sol,
    input  logic                 in_eol,
    input  logic                 in_fv,
    output logic                 out_valid,
    output logic [PIX_W-1:0]     out_pix,
    output logic [SUBLINE_W-1:0] out_sub_line,
    output logic                 out_sub_pix
);
    localparam int COL_W = $clog2(LINE_MAX);
    localparam beat_idx_t LAST_BEAT = beat_idx_t'(BEATS - 1);

    typedef struct packed {
        logic                 fv;
        logic                 first;
        logic [COL_W-1:0]     col;
        logic [PIX_W-1:0]     hold_c;
        logic [PIX_W-1:0]     hold_p;
        logic [PIX_W-1:0]     g_c0;
        logic [PIX_W-1:0]     g_c1;
        logic [PIX_W-1:0]     g_p0;
        logic [PIX_W-1:0]     g_p1;
        logic                 busy;
        beat_idx_t            cnt;
        logic                 pend;
        logic [PIX_W-1:0]     pend_c;
        logic [PIX_W-1:0]     pend_p;
        logic                 ov;
        logic [PIX_W-1:0]     opix;
        logic [SUBLINE_W-1:0] oline;
        logic                 osub;
    } st_t;

    st_t st_d, st_q;

    logic [COL_W-1:0] lb_addr;
    logic [PIX_W-1:0] lb_rdata;
    logic [PIX_W-1:0] prev_pix;
    logic [PIX_W-1:0] samp;
    logic             fv_rise;
    logic             first_eff;

    upscale_linebuf #(.PIX_W(PIX_W), .DEPTH(LINE_MAX)) u_lb (
        .clk   (clk),
        .rst   (rst),
        .we    (in_valid),
        .addr  (lb_addr),
        .wdata (in_pix),
        .rdata (lb_rdata)
    );

    upscale_sample #(.PIX_W(PIX_W)) u_samp (
        .cur_a    (st_q.g_c0),
        .cur_b    (st_q.g_c1),
        .prv_a    (st_q.g_p0),
        .prv_b    (st_q.g_p1),
        .sub_line (st_q.cnt[IDX_W-1:1]),
        .sub_pix  (st_q.cnt[0]),
        .samp     (samp)
    );

    always_comb begin
        st_d      = st_q;
        fv_rise   = in_fv & ~st_q.fv;
        first_eff = st_q.first | fv_rise;
        lb_addr   = in_sol ? '0 : st_q.col + 1'b1;
        prev_pix  = first_eff ? in_pix : lb_rdata;

        st_d.fv = in_fv;
        if (fv_rise) st_d.first = 1'b1;

        // output register follows the beat engine by one cycle
        st_d.ov    = st_q.busy;
        st_d.opix  = samp;
        st_d.oline = st_q.cnt[IDX_W-1:1];
        st_d.osub  = st_q.cnt[0];

        // beat engine
        if (st_q.busy) begin
            if (st_q.cnt == LAST_BEAT) begin
                if (st_q.pend) begin
                    st_d.g_c0 = st_q.pend_c;
                    st_d.g_c1 = st_q.pend_c;
                    st_d.g_p0 = st_q.pend_p;
                    st_d.g_p1 = st_q.pend_p;
                    st_d.cnt  = '0;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // pixel acceptance
        if (in_valid) begin
            st_d.hold_c = in_pix;
            st_d.hold_p = prev_pix;
            st_d.col    = lb_addr;
            if (!in_sol) begin
                st_d.g_c0   = st_q.hold_c;
                st_d.g_c1   = in_pix;
                st_d.g_p0   = st_q.hold_p;
                st_d.g_p1   = prev_pix;
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.pend   = in_eol;
                st_d.pend_c = in_pix;
                st_d.pend_p = prev_pix;
            end else if (in_eol) begin
                st_d.g_c0 = in_pix;
                st_d.g_c1 = in_pix;
                st_d.g_p0 = prev_pix;
                st_d.g_p1 = prev_pix;
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.pend = 1'b0;
            end
            if (in_eol) st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.ov;
    assign out_pix      = st_q.opix;
    assign out_sub_line = st_q.oline;
    assign out_sub_pix  = st_q.osub;

    AST_GROUP_START: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ({out_sub_line, out_sub_pix} == '0)); // R2

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && ({out_sub_line, out_sub_pix} != '0))
        |-> ({out_sub_line, out_sub_pix} == $past({out_sub_line, out_sub_pix}) + 1'b1)); // R2

    AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && ({out_sub_line, out_sub_pix} == '0))
        |-> ($past({out_sub_line, out_sub_pix}) == LAST_BEAT)); // R2

    AST_IN_SPACING: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (!st_q.busy || (st_q.cnt == LAST_BEAT && !st_q.pend))); // R9

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid); // R1
endmodule

// File: tb/tb_upscale_2x4.sv
module tb_upscale_2x4;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       in_sol = 1'b0;
    logic       in_eol = 1'b0;
    logic       in_fv = 1'b0;
    logic       out_valid;
    logic [7:0] out_pix;
    logic [1:0] out_sub_line;
    logic       out_sub_pix;

    always #5 clk = ~clk;

    upscale_2x4 dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_sol(in_sol), .in_eol(in_eol), .in_fv(in_fv),
        .out_valid(out_valid), .out_pix(out_pix),
        .out_sub_line(out_sub_line), .out_sub_pix(out_sub_pix)
    );

    typedef struct {
        logic [7:0] pix;
        logic [1:0] sl;
        logic       sp;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 0;
    bit    mon_on = 0;

    // reference model state
    logic [7:0] mprev [768];
    bit         mfirst = 1;
    string      first_tag = "R6";
    logic [7:0] mhc, mhp;
    int         mcol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] vmix(logic [7:0] p, logic [7:0] c, int j);
        int t;
        t = ((4 - j) * p + j * c + 2) >> 2;
        return t[7:0];
    endfunction

    task automatic push_group(logic [7:0] c0, logic [7:0] c1, logic [7:0] p0,
                              logic [7:0] p1, int start, bit last, bit frst);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            int j, v0, v1;
            j  = i >> 1;
            v0 = vmix(p0, c0, j);
            v1 = vmix(p1, c1, j);
            e.sl  = j[1:0];
            e.sp  = i[0];
            e.pix = e.sp ? 8'((v0 + v1 + 1) >> 1) : 8'(v0);
            e.cyc = start + i;
            if (frst)      e.tag = first_tag;
            else if (!e.sp) e.tag = "R3";
            else if (last) e.tag = "R5";
            else           e.tag = "R4";
            expq.push_back(e);
        end
    endtask

    task automatic model_accept(logic [7:0] pix, bit sol, bit eol, int acc);
        int addr;
        logic [7:0] pv;
        bit f;
        f    = mfirst;
        addr = sol ? 0 : mcol + 1;
        pv   = f ? pix : mprev[addr];
        mprev[addr] = pix;
        if (!sol) begin
            push_group(mhc, pix, mhp, pv, acc + 1, 1'b0, f);
            if (eol) push_group(pix, pix, pv, pv, acc + 9, 1'b1, f);
        end else if (eol) begin
            push_group(pix, pix, pv, pv, acc + 1, 1'b1, f);
        end
        mhc = pix; mhp = pv; mcol = addr;
        if (eol) mfirst = 0;
    endtask

    // caller stands at a negedge
    task automatic drive_pix(logic [7:0] pix, bit sol, bit eol, int gap, bit raise_fv);
        int acc;
        in_valid = 1'b1; in_pix = pix; in_sol = sol; in_eol = eol;
        if (raise_fv) in_fv = 1'b1;
        @(posedge clk); #1;
        acc = cyc;
        model_accept(pix, sol, eol, acc);
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(int kind, int seed, int i);
        case (kind)
            1:       return (i % 2) ? 8'd255 : 8'd0;
            2:       return seed[0] ? 8'd255 : 8'd0;
            default: return 8'((seed * 37 + i * 53 + i * i * 7) & 255);
        endcase
    endfunction

    task automatic drive_line(int len, int kind, int seed, int gap, bit raise_fv);
        for (int i = 0; i < len; i++) begin
            bit eol;
            eol = (i == len - 1);
            drive_pix(pat(kind, seed, i), i == 0, eol,
                      (eol && gap < 16) ? 16 : gap, raise_fv && i == 0);
        end
    endtask

    task automatic new_field(string tag);
        @(negedge clk);
        in_fv = 1'b0;
        repeat (3) @(negedge clk);
        mfirst = 1;
        first_tag = tag;
    endtask

    task automatic drain(string tag);
        repeat (24) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL %s missing beats: actual pending=%0d expected 0", tag, expq.size());
            expq.delete();
        end
    endtask

    // monitor: sample between edges
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (expq.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 unexpected beat: actual pix=%0d expected none", out_pix);
            end else begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (out_pix !== e.pix) begin
                    failures++;
                    $display("FAIL %s sample: actual %0d expected %0d", e.tag, out_pix, e.pix);
                end
                checks++;
                if (out_sub_line !== e.sl || out_sub_pix !== e.sp) begin
                    failures++;
                    $display("FAIL R2 index: actual %0d/%0d expected %0d/%0d",
                             out_sub_line, out_sub_pix, e.sl, e.sp);
                end
                checks++;
                if (cyc != e.cyc) begin
                    failures++;
                    $display("FAIL R7 timing: actual cycle %0d expected %0d", cyc, e.cyc);
                end
            end
        end
    end

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R1 out_valid after reset: actual %b expected 0", out_valid);
            end
        end
        mon_on = 1;
    endtask

    // first line with fv rising on its first pixel, then back-to-back lines
    task automatic t_first_and_dense;
        mfirst = 1; first_tag = "R6";
        drive_line(6, 0, 1, 8, 1'b1);
        drive_line(6, 0, 2, 8, 1'b0);   // R3 R4 R5 at minimum spacing
        drain("R9");
    endtask

    task automatic t_slow;
        drive_line(6, 0, 3, 21, 1'b0);  // R7 with idle gaps
        drain("R7");
    endtask

    task automatic t_single;
        new_field("R8");
        drive_line(1, 0, 4, 16, 1'b1);
        drive_line(1, 0, 5, 16, 1'b0);  // R5 one-pixel line with a stored row
        drain("R5");
    endtask

    task automatic t_extremes;
        new_field("R8");
        drive_line(4, 2, 0, 8, 1'b1);
        drive_line(4, 2, 1, 8, 1'b0);   // R3 rounding 0 -> 255
        drive_line(4, 1, 0, 8, 1'b0);   // R4 alternating extremes
        drain("R4");
    endtask

    task automatic t_restart;
        new_field("R8");
        drive_line(5, 0, 9, 8, 1'b1);   // stale buffer must be ignored
        drive_line(5, 0, 10, 8, 1'b0);
        drain("R8");
    endtask

    task automatic t_full;
        new_field("R8");
        drive_line(768, 0, 11, 8, 1'b1);
        drive_line(768, 0, 12, 8, 1'b0); // R10 every column of a full line
        drain("R10");
    endtask

    initial begin
        t_reset();
        t_first_and_dense();
        t_slow();
        t_single();
        t_extremes();
        t_restart();
        t_full();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule